// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block Memory

This block models an 18-kilobit memory with two ports, A and B, that share one storage array. Each port has its own clock enable, address, write data, byte write enables, active-low synchronous output reset and a registered read output. Each port's data width is a parameter and is chosen on its own. A 36-bit port and a 1-bit port can therefore address the same bits at the same time, each with its own aspect ratio.

The storage holds 512 words. Each word has four 9-bit bytes. Ports 9, 18 and 36 bits wide reach every bit of a byte. Ports 1, 2 and 4 bits wide reach only the low eight bits of each byte. Each port's output register has its own behaviour when that port writes: it shows the old contents, it shows the new contents, or it holds. The output register's power-up value, its reset value and the whole array's preload are parameters.

Both ports are clocked by one shared clock. This makes same-edge collisions between the ports deterministic.

Top module: `tdpram`

## Requirements
- R1: Storage is 512 words of 36 bits. Each word holds four 9-bit bytes, and byte j occupies bits [9j+8:9j]. Port width is a parameter from the set 1, 2, 4, 9, 18, 36. The address is 14, 13, 12, 11, 10 or 9 bits wide for these widths. The top 9 address bits always pick the word.
- R2: On a 18-bit or 36-bit port, write-enable bit j covers port data bits [9j+8:9j]. Only bytes whose enable is set are changed. A 1-, 2-, 4- or 9-bit port has a single enable.
- R3: The address bits below the top 9 pick a sub-word, and sub-word 0 sits at the least significant end of the word. A 9-bit address 4n+j reaches byte j of word n. A 18-bit address 2n+h reaches bytes 2h and 2h+1 of word n.
- R4: On a 1-, 2- or 4-bit port, data bit k of a word (k from 0 to 31) is bit k mod 8 of byte k/8. Bit 8 of each byte cannot be read or written from such a port, and writes from such a port leave it unchanged.
- R5: While a port's enable is low, that port does nothing: it does not write, its output does not change, and its reset is ignored.
- R6: In hold mode, an enabled write leaves that port's output unchanged.
- R7: In new-data mode, an enabled write makes that port's output show, on the next cycle, the addressed sub-word as it stands after that port's write.
- R8: In old-data mode, an enabled write makes that port's output show the sub-word's contents from before the write. A port that reads a location the other port writes on the same edge receives the old contents.
- R9: When a port's enable is high and its reset input is low, that port's output loads its reset-value parameter. Reset has priority over reads and writes.
- R10: Each output register starts at its power-up parameter. The array starts with the preload parameter, where word i is taken from preload bits [36i+35:36i].
- R11: When both ports write the same bit on the same edge, port A's value is stored. Bits written by only one of the ports keep that port's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge |
| a_en | input | 1 | Port A clock enable |
| a_rst_n | input | 1 | Port A output reset, active low, synchronous |
| a_we | input | max(1, A_W/9) | Port A byte write enables |
| a_addr | input | addr_bits(A_W) | Port A address |
| a_din | input | A_W | Port A write data |
| a_dout | output | A_W | Port A registered read data |
| b_en | input | 1 | Port B clock enable |
| b_rst_n | input | 1 | Port B output reset, active low, synchronous |
| b_we | input | max(1, B_W/9) | Port B byte write enables |
| b_addr | input | addr_bits(B_W) | Port B address |
| b_din | input | B_W | Port B write data |
| b_dout | output | B_W | Port B registered read data |

## Verification
The storage array has no observer of its own. A bad stored byte or a wrong sub-word decode therefore becomes visible only when some port reads that location: the wrong value appears on that port's output one cycle after the address is presented. Reading the same word through a port of a different width exposes lane and ninth-bit placement errors that a same-width read-back would hide. A wrong per-port mode shows on the output in the cycle right after a write. A broken collision rule shows on the first read after the shared edge.

// File: rtl/tdpram_pkg.sv
// Package: shared sizes, the output-on-write mode type, and the
// functions that place a port's sub-word inside a 36-bit storage word.
// Assumes port widths come from the set 1, 2, 4, 9, 18, 36.
package tdpram_pkg;

    localparam int BYTE_W  = 9;
    localparam int BYTES   = 4;
    localparam int WORD_W  = BYTE_W * BYTES;
    localparam int DEPTH   = 512;
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int SEL_W   = 5;
    localparam int NARROW_BYTE = 8;

    typedef enum logic [1:0] {
        WM_READ_FIRST  = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

    // Address width for a port of width w.
    function automatic int addr_bits(input int w);
        case (w)
            1:       return 14;
            2:       return 13;
            4:       return 12;
            9:       return 11;
            18:      return 10;
            default: return 9;
        endcase
    endfunction

    // Number of write-enable bits for a port of width w.
    function automatic int we_bits(input int w);
        return (w >= BYTE_W) ? (w / BYTE_W) : 1;
    endfunction

    // Physical position of data bit k when the ninth bits are skipped.
    function automatic int phys_bit(input int k);
        return k + (k / NARROW_BYTE);
    endfunction

    // Extract sub-word sel of width w, returned in the low bits.
    function automatic logic [WORD_W-1:0] pick(input logic [WORD_W-1:0] word,
                                               input int w, input int sel);
        logic [WORD_W-1:0] r;
        r = '0;
        if (w >= BYTE_W) begin
            r = word >> (sel * w);
        end else begin
            for (int i = 0; i < 4; i++)
                if (i < w) r[i] = word[phys_bit(sel * w + i)];
        end
        return r;
    endfunction

    // Bits of the storage word touched by a write of sub-word sel.
    function automatic logic [WORD_W-1:0] lane_mask(input int w, input int sel,
                                                    input logic [BYTES-1:0] we);
        logic [WORD_W-1:0] m;
        m = '0;
        if (w >= BYTE_W) begin
            for (int j = 0; j < BYTES; j++)
                if (j < w / BYTE_W && we[j])
                    m[(sel * (w / BYTE_W) + j) * BYTE_W +: BYTE_W] = '1;
        end else begin
            for (int i = 0; i < 4; i++)
                if (i < w && we[0]) m[phys_bit(sel * w + i)] = 1'b1;
        end
        return m;
    endfunction

    // Port data moved to its place in the storage word.
    function automatic logic [WORD_W-1:0] lane_data(input int w, input int sel,
                                                    input logic [WORD_W-1:0] din);
        logic [WORD_W-1:0] d;
        d = '0;
        if (w >= BYTE_W) begin
            d = din << (sel * w);
        end else begin
            for (int i = 0; i < 4; i++)
                if (i < w) d[phys_bit(sel * w + i)] = din[i];
        end
        return d;
    endfunction

endpackage

// File: rtl/tdpram_lane.sv
// Port decoder: splits a port address into word index and sub-word
// select, and turns write data and enables into a word-aligned value
// and bit mask. Purely combinational; assumes W is a legal port width.
module tdpram_lane
    import tdpram_pkg::*;
#(
    parameter int W = 36
) (
    input  logic                     en,
    input  logic [addr_bits(W)-1:0]  addr,
    input  logic [we_bits(W)-1:0]    we,
    input  logic [W-1:0]             din,
    output logic [IDX_W-1:0]         idx,
    output logic [SEL_W-1:0]         sel,
    output logic                     wr,
    output logic [WORD_W-1:0]        mask,
    output logic [WORD_W-1:0]        data
);
    localparam int AW   = addr_bits(W);
    localparam int SUBW = AW - IDX_W;

    logic [13:0]      addr14;
    logic [BYTES-1:0] we4;

    // Split the address into word index and sub-word number.
    always_comb begin
        addr14 = 14'(addr);
        idx    = IDX_W'(addr14 >> SUBW);
        sel    = SEL_W'(addr14 & 14'((1 << SUBW) - 1));
    end

    // Build the gated enable vector, mask and aligned write data.
    always_comb begin
        we4  = BYTES'(we) & {BYTES{en}};
        wr   = |we4;
        mask = lane_mask(W, int'(sel), we4);
        data = lane_data(W, int'(sel), WORD_W'(din));
    end

endmodule

// File: rtl/tdpram_outreg.sv
// Port output register: picks the port's sub-word out of the old or
// updated storage word and applies reset, read and the write mode.
// Assumes old_word/new_word already reflect this cycle's addresses.
module tdpram_outreg
    import tdpram_pkg::*;
#(
    parameter int             W    = 36,
    parameter wmode_e         MODE = WM_READ_FIRST,
    parameter logic [W-1:0]   INIT = '0,
    parameter logic [W-1:0]   RSTV = '0
) (
    input  logic               clk,
    input  logic               en,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [SEL_W-1:0]   sel,
    input  logic [WORD_W-1:0]  old_word,
    input  logic [WORD_W-1:0]  new_word,
    output logic [W-1:0]       q
);
    logic [W-1:0] q_r = INIT;
    logic [W-1:0] old_d;
    logic [W-1:0] wr_val;

    assign old_d = W'(pick(old_word, W, int'(sel)));
    assign q     = q_r;

    // Value loaded on a write, chosen by the mode parameter.
    generate
        if (MODE == WM_WRITE_FIRST) begin : g_new
            assign wr_val = W'(pick(new_word, W, int'(sel)));
        end else if (MODE == WM_NO_CHANGE) begin : g_hold
            logic hold_unused;
            assign hold_unused = ^new_word;
            assign wr_val = q_r;
        end else begin : g_old
            logic old_unused;
            assign old_unused = ^new_word;
            assign wr_val = old_d;
        end
    endgenerate

    // Output register: gated by enable, reset first, then write or read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (!rst_n)  q_r <= RSTV;
            else if (wr) q_r <= wr_val;
            else         q_r <= old_d;
        end
    end

endmodule

// File: rtl/tdpram.sv
// Two-port memory of 512 x 36 bits with per-port width and write mode.
// Both ports share clk; same-edge overlapping writes resolve to port A.
// Assumes A_W and B_W are legal widths and the preload is 18432 bits.
module tdpram
    import tdpram_pkg::*;
#(
    parameter int                        A_W      = 36,
    parameter int                        B_W      = 9,
    parameter wmode_e                    A_MODE   = WM_WRITE_FIRST,
    parameter wmode_e                    B_MODE   = WM_READ_FIRST,
    parameter logic [A_W-1:0]            A_INIT   = '0,
    parameter logic [A_W-1:0]            A_RSTVAL = '0,
    parameter logic [B_W-1:0]            B_INIT   = '0,
    parameter logic [B_W-1:0]            B_RSTVAL = '0,
    parameter logic [DEPTH*WORD_W-1:0]   PRELOAD  = '0
) (
    input  logic                      clk,
    input  logic                      a_en,
    input  logic                      a_rst_n,
    input  logic [we_bits(A_W)-1:0]   a_we,
    input  logic [addr_bits(A_W)-1:0] a_addr,
    input  logic [A_W-1:0]            a_din,
    output logic [A_W-1:0]            a_dout,
    input  logic                      b_en,
    input  logic                      b_rst_n,
    input  logic [we_bits(B_W)-1:0]   b_we,
    input  logic [addr_bits(B_W)-1:0] b_addr,
    input  logic [B_W-1:0]            b_din,
    output logic [B_W-1:0]            b_dout
);
    logic [WORD_W-1:0] mem [DEPTH];

    logic [IDX_W-1:0]  a_idx, b_idx;
    logic [SEL_W-1:0]  a_sel, b_sel;
    logic              a_wr, b_wr, same_word;
    logic [WORD_W-1:0] a_mask, b_mask, a_data, b_data;
    logic [WORD_W-1:0] a_old, b_old, a_base, a_new, b_new;

    // Load the array from the preload parameter.
    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = PRELOAD[i*WORD_W +: WORD_W];
    end

    tdpram_lane #(.W(A_W)) u_lane_a (
        .en(a_en), .addr(a_addr), .we(a_we), .din(a_din),
        .idx(a_idx), .sel(a_sel), .wr(a_wr), .mask(a_mask), .data(a_data)
    );

    tdpram_lane #(.W(B_W)) u_lane_b (
        .en(b_en), .addr(b_addr), .we(b_we), .din(b_din),
        .idx(b_idx), .sel(b_sel), .wr(b_wr), .mask(b_mask), .data(b_data)
    );

    // Merge each port's write into its word; A is layered over B on a shared word.
    always_comb begin
        a_old     = mem[a_idx];
        b_old     = mem[b_idx];
        same_word = a_wr && b_wr && (a_idx == b_idx);
        b_new     = (b_old & ~b_mask) | (b_data & b_mask);
        a_base    = same_word ? b_new : a_old;
        a_new     = (a_base & ~a_mask) | (a_data & a_mask);
    end

    // Storage update: B first, A last so A's bits win on a shared word.
    always_ff @(posedge clk) begin
        if (b_wr) mem[b_idx] <= b_new;
        if (a_wr) mem[a_idx] <= a_new;
    end

    tdpram_outreg #(.W(A_W), .MODE(A_MODE), .INIT(A_INIT), .RSTV(A_RSTVAL)) u_out_a (
        .clk(clk), .en(a_en), .rst_n(a_rst_n), .wr(a_wr), .sel(a_sel),
        .old_word(a_old), .new_word(a_new), .q(a_dout)
    );

    tdpram_outreg #(.W(B_W), .MODE(B_MODE), .INIT(B_INIT), .RSTV(B_RSTVAL)) u_out_b (
        .clk(clk), .en(b_en), .rst_n(b_rst_n), .wr(b_wr), .sel(b_sel),
        .old_word(b_old), .new_word(b_new), .q(b_dout)
    );

endmodule

// File: rtl/tdpram_chk.sv
// Checker: port-level properties of the two output registers.
// Bound into every tdpram instance; observes ports only.
module tdpram_chk
    import tdpram_pkg::*;
#(
    parameter int             A_W      = 36,
    parameter int             B_W      = 9,
    parameter wmode_e         A_MODE   = WM_WRITE_FIRST,
    parameter wmode_e         B_MODE   = WM_READ_FIRST,
    parameter logic [A_W-1:0] A_RSTVAL = '0,
    parameter logic [B_W-1:0] B_RSTVAL = '0
) (
    input logic                    clk,
    input logic                    a_en,
    input logic                    a_rst_n,
    input logic [we_bits(A_W)-1:0] a_we,
    input logic [A_W-1:0]          a_din,
    input logic [A_W-1:0]          a_dout,
    input logic                    b_en,
    input logic                    b_rst_n,
    input logic [we_bits(B_W)-1:0] b_we,
    input logic [B_W-1:0]          b_din,
    input logic [B_W-1:0]          b_dout
);
    // R5: a disabled port keeps its output
    a_r5_idle_hold_a: assert property (@(posedge clk) disable iff (!a_rst_n)
        !a_en |=> $stable(a_dout));
    a_r5_idle_hold_b: assert property (@(posedge clk) disable iff (!b_rst_n)
        !b_en |=> $stable(b_dout));

    // R9: enabled reset loads the reset value
    a_r9_srst_a: assert property (@(posedge clk) disable iff (1'b0)
        (a_en && !a_rst_n) |=> (a_dout == A_RSTVAL));
    a_r9_srst_b: assert property (@(posedge clk) disable iff (1'b0)
        (b_en && !b_rst_n) |=> (b_dout == B_RSTVAL));

    // R6: hold mode keeps the output across a write
    a_r6_hold_a: assert property (@(posedge clk) disable iff (!a_rst_n)
        (A_MODE == WM_NO_CHANGE && a_en && (|a_we)) |=> $stable(a_dout));
    a_r6_hold_b: assert property (@(posedge clk) disable iff (!b_rst_n)
        (B_MODE == WM_NO_CHANGE && b_en && (|b_we)) |=> $stable(b_dout));

    // R7: new-data mode with every enable set returns the written data
    a_r7_new_a: assert property (@(posedge clk) disable iff (!a_rst_n)
        (A_MODE == WM_WRITE_FIRST && a_en && (&a_we)) |=> (a_dout == $past(a_din)));
    a_r7_new_b: assert property (@(posedge clk) disable iff (!b_rst_n)
        (B_MODE == WM_WRITE_FIRST && b_en && (&b_we)) |=> (b_dout == $past(b_din)));

endmodule

bind tdpram tdpram_chk #(
    .A_W(A_W), .B_W(B_W), .A_MODE(A_MODE), .B_MODE(B_MODE),
    .A_RSTVAL(A_RSTVAL), .B_RSTVAL(B_RSTVAL)
) u_chk (
    .clk(clk),
    .a_en(a_en), .a_rst_n(a_rst_n), .a_we(a_we), .a_din(a_din), .a_dout(a_dout),
    .b_en(b_en), .b_rst_n(b_rst_n), .b_we(b_we), .b_din(b_din), .b_dout(b_dout)
);

// File: tb/tb_tdpram.sv
// Directed bench: dut is 36-bit new-data A with 9-bit old-data B;
// dut2 is 4-bit hold-mode A with 18-bit new-data B.
module tb_tdpram;
    import tdpram_pkg::*;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [35:0] W0 = 36'h1_2345_6789;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int vectors = 0;
    int errs    = 0;
    bit done    = 1'b0;

    // dut signals
    logic        a_en = 0, a_rst_n = 1;
    logic [3:0]  a_we = 0;
    logic [8:0]  a_addr = 0;
    logic [35:0] a_din = 0, a_dout;
    logic        b_en = 0, b_rst_n = 1;
    logic [0:0]  b_we = 0;
    logic [10:0] b_addr = 0;
    logic [8:0]  b_din = 0, b_dout;

    // dut2 signals
    logic        c_en = 0, c_rst_n = 1;
    logic [0:0]  c_we = 0;
    logic [11:0] c_addr = 0;
    logic [3:0]  c_din = 0, c_dout;
    logic        d_en = 0, d_rst_n = 1;
    logic [1:0]  d_we = 0;
    logic [9:0]  d_addr = 0;
    logic [17:0] d_din = 0, d_dout;

    tdpram #(
        .A_W(36), .B_W(9), .A_MODE(WM_WRITE_FIRST), .B_MODE(WM_READ_FIRST),
        .A_INIT(36'hABC), .A_RSTVAL(36'h5A5), .B_INIT(9'h1FF), .B_RSTVAL(9'h0AA),
        .PRELOAD((DEPTH*WORD_W)'(W0))
    ) dut (
        .clk(clk),
        .a_en(a_en), .a_rst_n(a_rst_n), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_dout(a_dout),
        .b_en(b_en), .b_rst_n(b_rst_n), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_dout(b_dout)
    );

    tdpram #(
        .A_W(4), .B_W(18), .A_MODE(WM_NO_CHANGE), .B_MODE(WM_WRITE_FIRST)
    ) dut2 (
        .clk(clk),
        .a_en(c_en), .a_rst_n(c_rst_n), .a_we(c_we), .a_addr(c_addr), .a_din(c_din), .a_dout(c_dout),
        .b_en(d_en), .b_rst_n(d_rst_n), .b_we(d_we), .b_addr(d_addr), .b_din(d_din), .b_dout(d_dout)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [35:0] bmerge(input logic [35:0] old_w, input logic [35:0] new_w,
                                           input logic [3:0] we);
        logic [35:0] r;
        for (int j = 0; j < 4; j++) r[j*9 +: 9] = we[j] ? new_w[j*9 +: 9] : old_w[j*9 +: 9];
        return r;
    endfunction

    task automatic t_powerup();
        #1;
        chk("R10 a power-up", a_dout, 36'hABC);
        chk("R10 b power-up", 36'(b_dout), 36'h1FF);
        chk("R10 dut2 power-up", 36'({c_dout, d_dout}), 36'h0);
        a_rst_n = 0; a_we = 4'hF; a_din = 36'hFFF;
        @(negedge clk);
        tick(); tick();
        chk("R5 disabled a", a_dout, 36'hABC);
        a_rst_n = 1; a_we = 0;
    endtask

    task automatic t_preload();
        a_en = 1; a_addr = 9'd0; b_en = 1; b_addr = 11'd2;
        tick();
        chk("R10 R1 preload word", a_dout, W0);
        chk("R3 R10 preload byte", 36'(b_dout), 36'(W0[18 +: 9]));
        b_en = 0;
    endtask

    task automatic t_bytes();
        logic [35:0] w1 = 36'hF_0F0F_0F0F;
        logic [35:0] w2 = 36'hA_BCDE_F012;
        a_addr = 9'd5; a_din = w1; a_we = 4'hF;
        tick();
        chk("R7 full write", a_dout, w1);
        a_din = w2; a_we = 4'b0101;
        tick();
        chk("R2 R7 byte write", a_dout, bmerge(w1, w2, 4'b0101));
        a_we = 0; a_en = 0;
        for (int j = 0; j < 4; j++) begin
            b_en = 1; b_addr = 11'(5*4 + j);
            tick();
            chk("R3 byte lanes", 36'(b_dout), 36'(bmerge(w1, w2, 4'b0101) >> (9*j)) & 36'h1FF);
        end
    endtask

    task automatic t_oldfirst();
        logic [35:0] w = bmerge(36'hF_0F0F_0F0F, 36'hA_BCDE_F012, 4'b0101);
        b_en = 1; b_addr = 11'd20; b_din = 9'h155; b_we = 1;
        tick();
        chk("R8 own write old", 36'(b_dout), 36'(w[8:0]));
        b_we = 0;
        tick();
        chk("R8 read back", 36'(b_dout), 36'h155);
        b_en = 0; a_en = 1; a_addr = 9'd5;
        tick();
        chk("R3 wide sees narrow", a_dout, {w[35:9], 9'h155});
        a_addr = 9'd6; b_en = 1; b_addr = 11'd24; b_din = 9'h0C3; b_we = 1;
        tick();
        chk("R8 cross-port old", a_dout, 36'h0);
        b_en = 0; b_we = 0;
        tick();
        chk("R8 cross-port new", a_dout, 36'h0C3);
    endtask

    task automatic t_collide();
        logic [35:0] x = 36'h9_8765_4321;
        logic [35:0] z = 36'h3_3333_3333;
        a_en = 1; a_addr = 9'd7; a_din = x; a_we = 4'hF;
        b_en = 1; b_addr = 11'd28; b_din = 9'h1EE; b_we = 1;
        tick();
        a_addr = 9'd8; a_din = z; a_we = 4'b1110; b_addr = 11'd32;
        tick();
        a_we = 0; b_en = 0; b_we = 0; a_addr = 9'd7;
        tick();
        chk("R11 overlap A wins", a_dout, x);
        a_addr = 9'd8;
        tick();
        chk("R11 disjoint merge", a_dout, {z[35:9], 9'h1EE});
    endtask

    task automatic t_idle_reset();
        a_addr = 9'd0;
        tick();
        a_en = 0; a_we = 4'hF; a_din = 36'h0_DEAD_BEEF; a_rst_n = 0;
        tick(); tick();
        chk("R5 idle output", a_dout, W0);
        a_en = 1; a_we = 0; a_rst_n = 1;
        tick();
        chk("R5 idle no write", a_dout, W0);
        a_rst_n = 0;
        tick();
        chk("R9 reset a", a_dout, 36'h5A5);
        a_rst_n = 1; a_en = 0;
        b_en = 1; b_addr = 11'd0;
        tick();
        b_en = 0; b_rst_n = 0;
        tick();
        chk("R5 reset gated b", 36'(b_dout), 36'(W0[8:0]));
        b_en = 1;
        tick();
        chk("R9 reset b", 36'(b_dout), 36'h0AA);
        b_en = 0; b_rst_n = 1;
    endtask

    task automatic t_narrow();
        logic [3:0] exp_nib [4] = '{4'h5, 4'hA, 4'hC, 4'h3};
        d_en = 1; d_addr = 10'd0; d_din = {9'h13C, 9'h1A5}; d_we = 2'b11;
        tick();
        chk("R7 18-bit new", 36'(d_dout), 36'({9'h13C, 9'h1A5}));
        d_en = 0; d_we = 0;
        for (int k = 0; k < 4; k++) begin
            c_en = 1; c_addr = 12'(k);
            tick();
            chk("R4 nibble view", 36'(c_dout), 36'(exp_nib[k]));
        end
        c_addr = 12'd1; c_din = 4'h6; c_we = 1;
        tick();
        chk("R6 hold on write", 36'(c_dout), 36'h3);
        c_we = 0;
        tick();
        chk("R4 nibble written", 36'(c_dout), 36'h6);
        c_en = 0; d_en = 1; d_addr = 10'd0;
        tick();
        chk("R4 ninth bit kept", 36'(d_dout), 36'({9'h13C, 9'h165}));
        d_addr = 10'd1;
        tick();
        chk("R3 R1 upper half", 36'(d_dout), 36'h0);
        d_en = 0;
    endtask

    initial begin
        t_powerup();
        t_preload();
        t_bytes();
        t_oldfirst();
        t_collide();
        t_idle_reset();
        t_narrow();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

endmodule